// File: doc/BRIEF.md
# PS/2 Host Port Register Interface

This block is the processor-facing register set for one PS/2 keyboard or mouse port. A simple word-addressed bus reaches six things: a control register, a status register, a data register, a clock-divider register, an interrupt status register and a read-only identification window at the top of a 4 KB region. On the device side, a byte-wide receive interface offers a byte together with a pending flag. A byte-wide transmit strobe carries host commands out to the device. The line-level serial framing is handled elsewhere.

Software reads the data register to take the offered byte. That read pops the device interface in the same cycle. The block keeps the last byte it took, and the status register reports the XOR parity of that byte. A single level interrupt combines the pending flag, gated by a receive enable, with an always-on transmit enable. The clock-divider value is only stored and drives nothing.

Bus reads are registered. `bus_rdata` holds the answer from the clock edge that accepts the read and keeps it until the next read.

Top module: `ps2_port_regs`

## Requirements
- R1: After reset the control, clock-divider and last-byte registers are zero, `irq`, `tx_strobe` and `rx_pop` are low, and a read of each stored register returns 0.
- R2: Control (byte offset 0x000) and clock divider (0x00C) keep the low 8 bits of a write and read them back zero-extended. A clock-divider write changes no other output.
- R3: Status (0x004) reads as: bit6 = 1 (transmit empty), bit4 = pending, bit2 = XOR of the 8 bits of the last taken byte. Bits 5, 3, 1, 0 and all bits above bit6 read 0.
- R4: A data read (0x008) while `rx_pending` is high raises `rx_pop` for that one cycle, returns `rx_byte` and stores it as the last byte.
- R5: A data read while nothing is pending leaves `rx_pop` low and returns the stored last byte.
- R6: Interrupt status (0x010) reads as bit1 = 1, bit0 = pending, with all other bits 0.
- R7: `irq` equals (pending AND control bit4) OR control bit3. It follows a control write at the same edge that stores the control value, and it follows a pending change one clock later.
- R8: A data write raises `tx_strobe` for one clock after the write edge, with `tx_byte` equal to write data bits 7:0.
- R9: Reads at byte offsets 0xFE0 to 0xFFC return one identification byte per word, in ascending address order: 0x50, 0x10, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R10: Reads of undefined offsets return 0. Writes to status, interrupt status, the identification window and undefined offsets change no stored register and raise no `tx_strobe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (12) | Byte address within the 4 KB region |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Registered read data |
| rx_pending | input | 1 | Device has a byte waiting |
| rx_byte | input | 8 | Byte offered by the device |
| rx_pop | output | 1 | Takes the offered byte this cycle |
| tx_strobe | output | 1 | One-cycle command send pulse |
| tx_byte | output | 8 | Command byte for the device |
| irq | output | 1 | Level interrupt |

## Verification
Two pairs of events can land in the same cycle.

The first pair is a control write and a rise of the pending flag. The bench offers a byte at the same falling edge on which it drives a control write that sets the receive enable. It then expects `irq` high straight after that edge, because the interrupt is computed from the incoming control value and the current pending flag.

The second pair is a data read and a byte offer. The bench offers a byte and reads the data register at once. It expects the new byte in the reply, a single pop counted on `rx_pop`, and a status parity that reflects the popped byte on the next status read.

// File: rtl/ps2r_pkg.sv
package ps2r_pkg;

  // word indices of the defined registers (byte address bits above 1:0)
  typedef enum logic [2:0] {
    IDX_CTRL  = 3'd0,
    IDX_STAT  = 3'd1,
    IDX_DATA  = 3'd2,
    IDX_CDIV  = 3'd3,
    IDX_ISTAT = 3'd4
  } reg_idx_e;

  // control register bit positions used by the interrupt
  localparam int RX_IE_BIT = 4;
  localparam int TX_IE_BIT = 3;

  // identification window: eight words at the top of the region
  localparam int ID_WORDS = 8;
  localparam int ID_SEL_W = $clog2(ID_WORDS);
  localparam int WIN_LSB  = ID_SEL_W + 2;

  typedef struct packed {
    logic                hit_ctrl;
    logic                hit_stat;
    logic                hit_data;
    logic                hit_cdiv;
    logic                hit_istat;
    logic                hit_id;
    logic [ID_SEL_W-1:0] id_sel;
  } dec_t;

  function automatic logic [7:0] id_byte(input logic [ID_SEL_W-1:0] n);
    logic [7:0] b;
    case (n)
      3'd0:    b = 8'h50;
      3'd1:    b = 8'h10;
      3'd2:    b = 8'h04;
      3'd3:    b = 8'h00;
      3'd4:    b = 8'h0D;
      3'd5:    b = 8'hF0;
      3'd6:    b = 8'h05;
      default: b = 8'hB1;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/ps2r_decode.sv
module ps2r_decode
  import ps2r_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output dec_t              dec
);

  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] widx;
  logic [1:0]       unused_lsb;

  assign widx       = addr[ADDR_W-1:2];
  assign unused_lsb = addr[1:0];

  always_comb begin
    dec        = '0;
    dec.hit_id = &addr[ADDR_W-1:WIN_LSB];
    dec.id_sel = addr[WIN_LSB-1:2];
    if (!dec.hit_id) begin
      case (widx)
        IDX_W'(IDX_CTRL):  dec.hit_ctrl  = 1'b1;
        IDX_W'(IDX_STAT):  dec.hit_stat  = 1'b1;
        IDX_W'(IDX_DATA):  dec.hit_data  = 1'b1;
        IDX_W'(IDX_CDIV):  dec.hit_cdiv  = 1'b1;
        IDX_W'(IDX_ISTAT): dec.hit_istat = 1'b1;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/ps2r_regs.sv
module ps2r_regs
  import ps2r_pkg::*;
#(
  parameter int CTRL_W = 8,
  parameter int CDIV_W = 8,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ctrl,
  input  logic              wr_cdiv,
  input  logic              wr_data,
  input  logic              rd_data,
  input  logic [CTRL_W-1:0] wr_ctrl_val,
  input  logic [CDIV_W-1:0] wr_cdiv_val,
  input  logic [BYTE_W-1:0] wr_byte_val,
  input  logic              rx_pending,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [CDIV_W-1:0] cdiv_q,
  output logic [BYTE_W-1:0] last_q,
  output logic              rx_pop,
  output logic              tx_strobe,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              irq
);

  logic [CTRL_W-1:0] ctrl_nxt;

  assign ctrl_nxt = wr_ctrl ? wr_ctrl_val : ctrl_q;
  // pop handshake: only when the device offers a byte
  assign rx_pop   = rd_data & rx_pending;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      cdiv_q    <= '0;
      last_q    <= '0;
      tx_strobe <= 1'b0;
      tx_byte   <= '0;
      irq       <= 1'b0;
    end else begin
      ctrl_q    <= ctrl_nxt;
      if (wr_cdiv) cdiv_q <= wr_cdiv_val;
      if (rx_pop)  last_q <= rx_byte;
      tx_strobe <= wr_data;
      if (wr_data) tx_byte <= wr_byte_val;
      irq       <= (rx_pending & ctrl_nxt[RX_IE_BIT]) | ctrl_nxt[TX_IE_BIT];
    end
  end

endmodule

// File: rtl/ps2r_rdmux.sv
module ps2r_rdmux
  import ps2r_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CTRL_W = 8,
  parameter int CDIV_W = 8,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  dec_t              dec,
  input  logic [CTRL_W-1:0] ctrl_q,
  input  logic [CDIV_W-1:0] cdiv_q,
  input  logic [BYTE_W-1:0] last_q,
  input  logic              rx_pending,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic [DATA_W-1:0] rdata
);

  logic [7:0]        stat_v;
  logic [DATA_W-1:0] rd_nxt;

  // transmit empty always set, pending at bit4, parity of last byte at bit2
  assign stat_v = {1'b0, 1'b1, 1'b0, rx_pending, 1'b0, ^last_q, 2'b00};

  always_comb begin
    rd_nxt = '0;
    if (dec.hit_id)         rd_nxt = DATA_W'(id_byte(dec.id_sel));
    else if (dec.hit_ctrl)  rd_nxt = DATA_W'(ctrl_q);
    else if (dec.hit_stat)  rd_nxt = DATA_W'(stat_v);
    else if (dec.hit_data)  rd_nxt = rx_pending ? DATA_W'(rx_byte) : DATA_W'(last_q);
    else if (dec.hit_cdiv)  rd_nxt = DATA_W'(cdiv_q);
    else if (dec.hit_istat) rd_nxt = DATA_W'({1'b1, rx_pending});
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_nxt;
  end

endmodule

// File: rtl/ps2_port_regs.sv
module ps2_port_regs
  import ps2r_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int CTRL_W = 8,
  parameter int CDIV_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              rx_pending,
  input  logic [7:0]        rx_byte,
  output logic              rx_pop,
  output logic              tx_strobe,
  output logic [7:0]        tx_byte,
  output logic              irq
);

  localparam int BYTE_W = 8;

  dec_t              dec;
  logic              wr_en, rd_en;
  logic [CTRL_W-1:0] ctrl_q;
  logic [CDIV_W-1:0] cdiv_q;
  logic [BYTE_W-1:0] last_q;

  assign wr_en = bus_sel &  bus_we;
  assign rd_en = bus_sel & ~bus_we;

  ps2r_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .dec  (dec)
  );

  ps2r_regs #(.CTRL_W(CTRL_W), .CDIV_W(CDIV_W), .BYTE_W(BYTE_W)) u_regs (
    .clk         (clk),
    .rst         (rst),
    .wr_ctrl     (wr_en & dec.hit_ctrl),
    .wr_cdiv     (wr_en & dec.hit_cdiv),
    .wr_data     (wr_en & dec.hit_data),
    .rd_data     (rd_en & dec.hit_data),
    .wr_ctrl_val (bus_wdata[CTRL_W-1:0]),
    .wr_cdiv_val (bus_wdata[CDIV_W-1:0]),
    .wr_byte_val (bus_wdata[BYTE_W-1:0]),
    .rx_pending  (rx_pending),
    .rx_byte     (rx_byte),
    .ctrl_q      (ctrl_q),
    .cdiv_q      (cdiv_q),
    .last_q      (last_q),
    .rx_pop      (rx_pop),
    .tx_strobe   (tx_strobe),
    .tx_byte     (tx_byte),
    .irq         (irq)
  );

  ps2r_rdmux #(.DATA_W(DATA_W), .CTRL_W(CTRL_W), .CDIV_W(CDIV_W), .BYTE_W(BYTE_W)) u_rd (
    .clk        (clk),
    .rst        (rst),
    .rd_en      (rd_en),
    .dec        (dec),
    .ctrl_q     (ctrl_q),
    .cdiv_q     (cdiv_q),
    .last_q     (last_q),
    .rx_pending (rx_pending),
    .rx_byte    (rx_byte),
    .rdata      (bus_rdata)
  );

  // upper write-data bits have no storage behind them
  logic unused_wdata;
  assign unused_wdata = ^bus_wdata;

endmodule

// File: rtl/ps2_port_regs_chk.sv
module ps2_port_regs_chk #(
  parameter int ADDR_W = 12,
  parameter int CTRL_W = 8,
  parameter int CDIV_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              rx_pending,
  input logic              rx_pop,
  input logic              tx_strobe,
  input logic              irq,
  input logic [CTRL_W-1:0] ctrl_q,
  input logic [CDIV_W-1:0] cdiv_q
);

  logic data_rd, data_wr, cdiv_wr;
  assign data_rd = bus_sel & ~bus_we & (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(2));
  assign data_wr = bus_sel &  bus_we & (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(2));
  assign cdiv_wr = bus_sel &  bus_we & (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(3));

  // R4 / R5: pop only during a data read with a byte offered
  a_r4_pop_on_data_read: assert property (@(posedge clk) disable iff (rst)
    rx_pop |-> (data_rd && rx_pending));
  a_r5_no_pop_when_empty: assert property (@(posedge clk) disable iff (rst)
    !rx_pending |-> !rx_pop);

  // R8: transmit pulse follows a data write
  a_r8_tx_after_write: assert property (@(posedge clk) disable iff (rst)
    tx_strobe |-> $past(data_wr));

  // R7: interrupt relation to control and pending
  a_r7_irq_level: assert property (@(posedge clk) disable iff (rst)
    irq == (($past(rx_pending) && ctrl_q[4]) || ctrl_q[3]));

  // R2: clock divider only moves on its own write
  a_r2_cdiv_hold: assert property (@(posedge clk) disable iff (rst)
    !cdiv_wr |=> $stable(cdiv_q));

endmodule

bind ps2_port_regs ps2_port_regs_chk #(
  .ADDR_W(ADDR_W), .CTRL_W(CTRL_W), .CDIV_W(CDIV_W)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .bus_sel    (bus_sel),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .rx_pending (rx_pending),
  .rx_pop     (rx_pop),
  .tx_strobe  (tx_strobe),
  .irq        (irq),
  .ctrl_q     (ctrl_q),
  .cdiv_q     (cdiv_q)
);

// File: tb/ps2_port_regs_tb_top.sv
`timescale 1ns/1ps
module ps2_port_regs_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sel = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        dev_pend = 1'b0;
  logic [7:0]  dev_byte = '0;
  logic        rx_pop, tx_strobe, irq;
  logic [7:0]  tx_byte;

  int total = 0, bad = 0, pop_cnt = 0;
  bit finished = 0;
  logic [7:0] last_exp = '0;
  logic       rd_vld_q = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  ps2_port_regs dut_i (
    .clk(clk), .rst(rst), .bus_sel(sel), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .rx_pending(dev_pend),
    .rx_byte(dev_byte), .rx_pop(rx_pop), .tx_strobe(tx_strobe),
    .tx_byte(tx_byte), .irq(irq)
  );

  // device model: a single-byte holder emptied by a pop
  always @(posedge clk) begin
    if (rx_pop) begin
      dev_pend <= 1'b0;
      pop_cnt  <= pop_cnt + 1;
    end
    rd_vld_q <= sel & ~we & ~rst;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // monitor: compare each registered read result against the scoreboard
  always @(negedge clk) begin
    if (rd_vld_q && exp_q.size() > 0) begin
      automatic logic [31:0] e = exp_q.pop_front();
      automatic string t = tag_q.pop_front();
      chk(rdata === e, t, rdata, e);
    end
  end

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); sel = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); sel = 0; we = 0;
  endtask

  task automatic bus_rd(input logic [11:0] a, input logic [31:0] e, input string t);
    @(negedge clk); sel = 1; we = 0; addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); sel = 0;
  endtask

  // data read: expected value comes from the bench's own device state
  task automatic data_rd(input string t);
    logic [31:0] e;
    @(negedge clk); sel = 1; we = 0; addr = 12'h008;
    if (dev_pend) last_exp = dev_byte;
    e = {24'h0, last_exp};
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); sel = 0;
  endtask

  function automatic logic [31:0] stat_exp();
    return 32'h40 | (32'(dev_pend) << 4) | (32'(^last_exp) << 2);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog", 0, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] id_tab [8] = '{8'h50, 8'h10, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    int pc;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(irq === 1'b0, "R1 irq", 32'(irq), 0);
    chk(tx_strobe === 1'b0, "R1 tx_strobe", 32'(tx_strobe), 0);
    chk(rx_pop === 1'b0, "R1 rx_pop", 32'(rx_pop), 0);
    bus_rd(12'h000, 0, "R1 ctrl");
    bus_rd(12'h00C, 0, "R1 cdiv");
    data_rd("R1 last byte");
    bus_rd(12'h004, 32'h40, "R3 status idle");
    bus_rd(12'h010, 32'h2, "R6 istat idle");

    // R7 transmit enable alone drives irq
    bus_wr(12'h000, 32'h08);
    chk(irq === 1'b1, "R7 tx enable", 32'(irq), 1);
    bus_rd(12'h000, 32'h08, "R2 ctrl readback");
    bus_wr(12'h000, 32'h1FF);
    bus_rd(12'h000, 32'hFF, "R2 ctrl low byte");
    bus_wr(12'h000, 32'h00);
    chk(irq === 1'b0, "R7 irq cleared", 32'(irq), 0);

    // R2 clock divider stored, nothing else moves
    bus_wr(12'h00C, 32'hAB3C);
    chk(irq === 1'b0 && tx_strobe === 1'b0, "R2 cdiv side effect", {30'b0, irq, tx_strobe}, 0);
    bus_rd(12'h00C, 32'h3C, "R2 cdiv readback");

    // R7 receive enable gated by pending, one cycle after pending rises
    bus_wr(12'h000, 32'h10);
    chk(irq === 1'b0, "R7 rx enable no pending", 32'(irq), 0);
    @(negedge clk); dev_pend = 1; dev_byte = 8'hA5;
    @(negedge clk);
    chk(irq === 1'b1, "R7 pending raises irq", 32'(irq), 1);
    bus_rd(12'h004, stat_exp(), "R3 status pending");
    bus_rd(12'h010, 32'h3, "R6 istat pending");

    // R4 pop on data read
    pc = pop_cnt;
    data_rd("R4 data pop");
    chk(dev_pend === 1'b0 && pop_cnt == pc + 1, "R4 single pop", 32'(pop_cnt - pc), 1);
    @(negedge clk);
    chk(irq === 1'b0, "R7 irq drops after pop", 32'(irq), 0);
    bus_rd(12'h004, stat_exp(), "R3 parity even");

    // R5 read with nothing pending
    pc = pop_cnt;
    data_rd("R5 repeat last");
    chk(pop_cnt == pc, "R5 no pop", 32'(pop_cnt - pc), 0);

    // concurrent: byte offered in the same cycle as the control write
    bus_wr(12'h000, 32'h00);
    @(negedge clk);
    dev_pend = 1; dev_byte = 8'h07;
    sel = 1; we = 1; addr = 12'h000; wdata = 32'h10;
    @(negedge clk); sel = 0; we = 0;
    chk(irq === 1'b1, "R7 same-cycle write and pending", 32'(irq), 1);
    // concurrent: pop of a freshly offered byte, then parity odd
    data_rd("R4 data pop 2");
    bus_rd(12'h004, 32'h44, "R3 parity odd");

    // R8 transmit
    bus_wr(12'h008, 32'h1F4);
    chk(tx_strobe === 1'b1 && tx_byte === 8'hF4, "R8 tx pulse", {23'b0, tx_strobe, tx_byte}, 32'h1F4);
    @(negedge clk);
    chk(tx_strobe === 1'b0, "R8 tx one cycle", 32'(tx_strobe), 0);

    // R9 identification window
    for (int i = 0; i < 8; i++)
      bus_rd(12'hFE0 + 12'(i * 4), 32'(id_tab[i]), "R9 id byte");

    // R10 undefined reads and ignored writes
    bus_rd(12'h014, 0, "R10 undefined 0x014");
    bus_rd(12'h800, 0, "R10 undefined 0x800");
    bus_rd(12'hFDC, 0, "R10 undefined 0xFDC");
    bus_wr(12'h004, 32'hFF);
    chk(tx_strobe === 1'b0, "R10 status write no tx", 32'(tx_strobe), 0);
    bus_wr(12'h010, 32'hFF);
    bus_wr(12'h020, 32'hFF);
    bus_wr(12'hFE8, 32'hFF);
    chk(tx_strobe === 1'b0, "R10 ignored writes no tx", 32'(tx_strobe), 0);
    bus_rd(12'h000, 32'h10, "R10 ctrl unchanged");
    bus_rd(12'h00C, 32'h3C, "R10 cdiv unchanged");
    data_rd("R10 last byte unchanged");

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "scoreboard drained", 32'(exp_q.size()), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule